// File: doc/BRIEF.md
# Load-Use Stall and Forwarding Control

This block is the hazard unit of a five-stage pipeline whose operand bypass sits in the decode stage. Branches compare their two source values during decode, so both operand selects are resolved there. The select for each source looks at the instructions one and two stages ahead. It picks one of four values: the register file read, the execute-stage ALU result, the memory-stage ALU result or the memory-stage load data.

A load in execute whose destination is needed by the decode instruction cannot be bypassed in time. The unit then raises `stall`, which the surrounding pipeline uses to hold the PC and the fetch/decode register. During a stall the decode instruction is issued a second time. To stop that copy from doing anything, the unit forces the register-write and memory-write enables it passes on toward the execute stage to zero. The datapath multiplexers and the pipeline registers are outside the block, and the block is purely combinational.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When neither later stage writes a matching non-zero register, `sel_a`/`sel_b` are 0 (register file data).
- R2: A select is 1 (execute ALU result) when `ex_wr` is 1, `ex_load` is 0, `ex_dst` is non-zero and `ex_dst` equals that source.
- R3: A select is 2 (memory ALU result) or 3 (memory load data, when `mem_load` is 1) when `mem_wr` is 1, `mem_dst` is non-zero, `mem_dst` equals that source and the execute stage does not match that source.
- R4: A matching execute-stage writer has priority over the memory stage. If that writer is a load, the select is 0 and the memory stage is not used.
- R5: Register 0 is never forwarded and never causes a stall.
- R6: `stall` is 1 exactly when `ex_wr` and `ex_load` are 1, `ex_dst` is non-zero and `ex_dst` equals `id_rs` with `id_use_rs` set or `id_rt` with `id_use_rt` set. A source whose use flag is clear causes no stall.
- R7: While `stall` is 1, `wreg_out` and `wmem_out` are 0. Otherwise they equal `wreg_in` and `wmem_in`.
- R8: A load to a register followed at once by an instruction that reads it gives one stall cycle. In the next cycle, with the load in the memory stage, the select for that source is 3 and there is no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source register number of the decode instruction |
| id_rt | input | REG_W | Second source register number of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads the first source |
| id_use_rt | input | 1 | Decode instruction reads the second source |
| ex_dst | input | REG_W | Destination register number in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination register number in memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wreg_in | input | 1 | Register-write enable decoded for the decode instruction |
| wmem_in | input | 1 | Memory-write enable decoded for the decode instruction |
| sel_a | output | 2 | Operand select for the first source |
| sel_b | output | 2 | Operand select for the second source |
| stall | output | 1 | Hold PC and fetch/decode register |
| wreg_out | output | 1 | Register-write enable passed toward execute |
| wmem_out | output | 1 | Memory-write enable passed toward execute |

## Verification
The bench targets the case where both later stages write the same register. A design with the priority reversed would bypass a stale memory-stage value. It also checks a load in execute that shadows a memory-stage match: a wrong design would select code 2 or 3 instead of stalling with code 0. Register 0 held as a destination in both stages is checked so that a design forwarding it would corrupt reads of the constant zero. A load-match on a source whose use flag is clear is checked so that a design ignoring the flag would insert false stalls. The two-cycle load-then-use sequence confirms one stall with both enables cleared, then code 3 from the memory stage.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_use_rs,
  input  logic             id_use_rt,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic             wreg_in,
  input  logic             wmem_in,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             stall,
  output logic             wreg_out,
  output logic             wmem_out
);
  localparam int NSRC = 2;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [REG_W-1:0] src   [NSRC];
  logic             used  [NSRC];
  logic [1:0]       sel   [NSRC];
  logic [NSRC-1:0]  ex_hit, mem_hit, ld_use;

  assign src[0]  = id_rs;
  assign src[1]  = id_rt;
  assign used[0] = id_use_rs;
  assign used[1] = id_use_rt;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign ex_hit[k]  = ex_wr  && (ex_dst  != ZERO_REG) && (ex_dst  == src[k]);
    assign mem_hit[k] = mem_wr && (mem_dst != ZERO_REG) && (mem_dst == src[k]);
    assign ld_use[k]  = ex_hit[k] && ex_load && used[k];
    assign sel[k] = ex_hit[k]  ? (ex_load  ? 2'd0 : 2'd1) :
                    mem_hit[k] ? (mem_load ? 2'd3 : 2'd2) : 2'd0;
  end

  assign sel_a    = sel[0];
  assign sel_b    = sel[1];
  assign stall    = |ld_use;
  assign wreg_out = wreg_in && !stall;
  assign wmem_out = wmem_in && !stall;

  always_comb begin
    if (!$isunknown({id_rs, id_rt, id_use_rs, id_use_rt, ex_dst, ex_wr, ex_load,
                     mem_dst, mem_wr, mem_load, wreg_in, wmem_in})) begin
      AST_ZERO_SRC_A: assert (id_rs != ZERO_REG || sel_a == 2'd0); // R5
      AST_ZERO_SRC_B: assert (id_rt != ZERO_REG || sel_b == 2'd0); // R5
      AST_EXE_SEL_A: assert (sel_a != 2'd1 || (ex_wr && !ex_load && ex_dst == id_rs)); // R2
      AST_MEM_SEL_A: assert (!sel_a[1] || (mem_wr && mem_dst == id_rs && mem_load == sel_a[0])); // R3
      AST_STALL_LOAD: assert (!stall || (ex_wr && ex_load && ex_dst != ZERO_REG)); // R6
      AST_CANCEL_QUIET: assert (!stall || (!wreg_out && !wmem_out)); // R7
    end
  end
endmodule

// File: tb/hazard_fwd_unit_test.sv
module hazard_fwd_unit_test;
  localparam int RW = 5;
  localparam int NV = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] id_rs = '0, id_rt = '0, ex_dst = '0, mem_dst = '0;
  logic id_use_rs = 1'b0, id_use_rt = 1'b0, ex_wr = 1'b0, ex_load = 1'b0;
  logic mem_wr = 1'b0, mem_load = 1'b0, wreg_in = 1'b0, wmem_in = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic stall, wreg_out, wmem_out;

  int runs = 0, fails = 0;

  hazard_fwd_unit #(.REG_W(RW)) uut (
    .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load),
    .wreg_in(wreg_in), .wmem_in(wmem_in),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall),
    .wreg_out(wreg_out), .wmem_out(wmem_out));

  // inputs: rs rt urs urt edst ewr eld mdst mwr mld wr wm | expected: sa sb st wro wmo
  localparam logic [34:0] TV [NV] = '{
    {5'd1, 5'd2, 1'b1, 1'b1, 5'd3, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    {5'd5, 5'd6, 1'b1, 1'b1, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0},
    {5'd7, 5'd7, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0},
    {5'd9, 5'd0, 1'b1, 1'b1, 5'd3, 1'b0, 1'b0, 5'd9, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0},
    {5'd8, 5'd9, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0},
    {5'd8, 5'd9, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0},
    {5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    {5'd1, 5'd9, 1'b1, 1'b0, 5'd9, 1'b1, 1'b1, 5'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1},
    {5'd4, 5'd2, 1'b1, 1'b1, 5'd4, 1'b0, 1'b1, 5'd4, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0},
    {5'd6, 5'd3, 1'b1, 1'b1, 5'd6, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0}
  };

  function automatic string tag(int i);
    case (i)
      0: tag = "R1 no match";
      1: tag = "R2 exe alu / R3 mem alu";
      2: tag = "R4 exe over mem";
      3: tag = "R3 mem load data";
      4: tag = "R6 R7 load-use stall";
      5: tag = "R8 post-stall mem load";
      6: tag = "R5 register zero";
      7: tag = "R6 unused source";
      8: tag = "R1 write disabled";
      default: tag = "R4 exe load shadows mem";
    endcase
  endfunction

  task automatic apply(input logic [27:0] v);
    @(negedge clk);
    {id_rs, id_rt, id_use_rs, id_use_rt, ex_dst, ex_wr, ex_load,
     mem_dst, mem_wr, mem_load, wreg_in, wmem_in} = v;
    #1;
  endtask

  task automatic check(input string name, input logic [6:0] exp);
    logic [6:0] got;
    got = {sel_a, sel_b, stall, wreg_out, wmem_out};
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got sa=%0d sb=%0d st=%0b wr=%0b wm=%0b expected sa=%0d sb=%0d st=%0b wr=%0b wm=%0b",
               name, got[6:5], got[4:3], got[2], got[1], got[0],
               exp[6:5], exp[4:3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin : watchdog
    #100000;
    runs++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    apply('0);
    check("R1 idle state", 7'b00_00_0_00);

    for (int i = 0; i < NV; i++) begin
      apply(TV[i][34:7]);
      check(tag(i), TV[i][6:0]);
    end

    // R8: lw r12 in execute, reader of r12 in decode, then lw moves to memory stage
    apply({5'd12, 5'd3, 1'b1, 1'b1, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0});
    check("R8 cycle 1 stall", 7'b00_00_1_00);
    apply({5'd12, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 1'b1, 1'b1, 1'b0});
    check("R8 cycle 2 forward", 7'b11_00_0_10);

    // R5: register zero as load destination in execute stalls nothing
    apply({5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1});
    check("R5 zero load no stall", 7'b00_00_0_11);

    // R7: pass-through of both enables without stall
    apply({5'd2, 5'd3, 1'b1, 1'b1, 5'd2, 1'b1, 1'b0, 5'd3, 1'b1, 1'b0, 1'b1, 1'b1});
    check("R7 pass-through", 7'b01_10_0_11);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule